// File: doc/BRIEF.md
# Serial Control Register Bank

This block is a write-only serial slave with three wires: an active-low select, a shift clock and a data line. It lives in the system clock domain and oversamples the three wires through a synchroniser. While the select is low, each rising edge of the shift clock captures one data bit. A complete frame is 16 bits. It holds a 2-bit operation code, a 4-bit register index and a 10-bit payload.

A frame takes effect only when the select returns high, and only if it received at least 16 shift-clock rises. A frame with fewer rises is dropped whole. Bits after the sixteenth are ignored. An external strap pin decides whether the operation code matters. Five 10-bit control words are held in the bank. The block decodes them into individual control fields: converter clock inversion, direct-input routing, low-rate mode, clamp options, pulse polarity, monitor selection, gain code, black target and AC-coupled test mode. Three of these fields are merged with device pins to give the standby, output high-impedance and black-reset controls.

None of the interfaces carries a data stream. All pins are plain control or status signals, so there is no valid/ready handshake and no back-pressure.

Top module: `ser_ctl_bank`

## Requirements
- R1: While `rst_n` is low, every register returns to its default. All words default to zero except word 3, which defaults to 64. The decoded outputs follow immediately, and `black_reset` is 1 while `rst_n` is low.
- R2: Bits are captured on `sck` rising edges while `cs_n` is low, in this order: O0, O1, A0..A3 (A0 is the address LSB), then D0..D9 (D0 is the payload LSB).
- R3: Outputs do not change during a frame. The new value appears only after `cs_n` rises.
- R4: A frame that received fewer than 16 `sck` rises leaves every register unchanged.
- R5: Rises after the sixteenth are ignored. The first 16 bits are committed.
- R6: With `op_bypass` high, any operation code writes. With `op_bypass` low, a frame writes only when O0=0 and O1=1.
- R7: Frames addressed to 5..15 leave every register unchanged.
- R8: Word 0 is decoded as follows:
  - D6 drives `adc_clk_inv`.
  - D5:D4 set the routing: 00 is off, 01 sets `dir_to_gain`, 1x sets `dir_to_conv`.
  - D3 drives `low_rate`.
  - D2 is output disable.
  - D1 is black reset.
  - D0 is standby.
- R9: Word 1 is decoded as follows:
  - D7 drives `clamp_fast`.
  - D6 drives `dir_clamp_off`.
  - D5:D4 drive `clamp_sel` (00 both, 01 reference only, 10 signal only, 11 off).
  - D3 drives `strobe_inv`.
  - D2 drives `enable_inv`.
  - D1:D0 drive `mon_sel`.
- R10: Word 2 D8:D0 drive `gain_code`. Word 3 D6:D0 drive `black_target`. Word 4 D6 drives `ac_couple`.
- R11: `standby` = word 0 D0 OR `stby_n` low. `out_hiz` = word 0 D2 OR `standby`. `black_reset` = word 0 D1 OR `rst_n` low.
- R12: `sck` edges while `cs_n` is high are ignored and do not affect the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial wires |
| rst_n | input | 1 | Active-low asynchronous reset; also feeds the black reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data |
| op_bypass | input | 1 | High: operation code ignored |
| stby_n | input | 1 | Standby pin, active low |
| adc_clk_inv | output | 1 | Converter clock inversion |
| dir_to_gain | output | 1 | Direct input routed to gain stage |
| dir_to_conv | output | 1 | Direct input routed to converter |
| low_rate | output | 1 | Reduced sample-rate mode |
| clamp_fast | output | 1 | Fast clamp current |
| dir_clamp_off | output | 1 | Clamp disabled for direct input |
| clamp_sel | output | 2 | Clamp target select |
| strobe_inv | output | 1 | Sample strobe polarity inversion |
| enable_inv | output | 1 | Enable pulse polarity inversion |
| mon_sel | output | 2 | Monitor source select |
| gain_code | output | 9 | Total gain code |
| black_target | output | 7 | Black level target code |
| ac_couple | output | 1 | AC-coupled direct-input test mode |
| standby | output | 1 | Merged standby |
| out_hiz | output | 1 | Merged converter output high-impedance |
| black_reset | output | 1 | Merged black-level reset |

## Verification
The hardest cases to reach from the ports are the malformed frames. These are a select that rises after 15 rises, a frame that overruns to 20 rises, and shift-clock activity while the select is high. In each of them the register file must look untouched. The driver builds every frame bit by bit with a chosen rise count and trailing pattern. It also checks the outputs while a complete frame is still held open with the select low, which shows the commit waits for the select edge. Opcode-gated frames are sent with the strap low using each of the four code pairs, and each one is followed by a compare against the model.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
  localparam int OP_BITS    = 2;
  localparam int ADDR_BITS  = 4;
  localparam int DATA_BITS  = 10;
  localparam int FRAME_BITS = OP_BITS + ADDR_BITS + DATA_BITS;
  localparam int NUM_REGS   = 5;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef logic [DATA_BITS-1:0] word_t;

  typedef enum logic [ADDR_BITS-1:0] {
    ADR_MODE_A = 4'd0,
    ADR_MODE_B = 4'd1,
    ADR_GAIN   = 4'd2,
    ADR_BLACK  = 4'd3,
    ADR_TEST   = 4'd4
  } reg_addr_e;

  // packed LSB-first so index k holds the k-th bit received
  typedef struct packed {
    word_t                 data;
    logic [ADDR_BITS-1:0]  addr;
    logic [OP_BITS-1:0]    op;
  } frame_t;

  localparam logic [OP_BITS-1:0] OP_WRITE = 2'b10;  // O1=1, O0=0
  localparam word_t BLACK_DEFAULT = word_t'(64);

  function automatic word_t reg_default(int idx);
    return (idx == int'(ADR_BLACK)) ? BLACK_DEFAULT : '0;
  endfunction
endpackage

// File: rtl/ser_ctl_sync.sv
module ser_ctl_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{RST_VAL}};
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/ser_ctl_shift.sv
module ser_ctl_shift
  import ser_ctl_pkg::*;
#(
  parameter int NBITS = FRAME_BITS,
  localparam int CW   = $clog2(NBITS + 1),
  localparam int IW   = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_s,
  input  logic             sck_s,
  input  logic             sdi_s,
  output logic [NBITS-1:0] frame,
  output logic             commit
);
  logic          cs_q, sck_q;
  logic [CW-1:0] cnt;
  logic          sck_rise, cs_fall, cs_rise;

  assign sck_rise = sck_s & ~sck_q;
  assign cs_fall  = cs_q & ~cs_n_s;
  assign cs_rise  = ~cs_q & cs_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_n_s;
      sck_q <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      frame <= '0;
    end else if (cs_fall) begin
      cnt <= '0;
    end else if (!cs_n_s && sck_rise && (cnt < CW'(NBITS))) begin
      frame[cnt[IW-1:0]] <= sdi_s;
      cnt                <= cnt + 1'b1;
    end
  end

  assign commit = cs_rise && (cnt == CW'(NBITS));

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (cnt == '0));  // R4

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> $stable(cnt));  // R12
endmodule

// File: rtl/ser_ctl_regs.sv
module ser_ctl_regs
  import ser_ctl_pkg::*;
#(
  parameter int NREGS = NUM_REGS,
  parameter int DW    = DATA_BITS,
  parameter int AW    = ADDR_BITS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  frame_t                    frame,
  input  logic                      op_bypass,
  output logic [NREGS-1:0][DW-1:0]  bank
);
  logic op_ok, addr_ok, wr;

  assign op_ok   = op_bypass || (frame.op == OP_WRITE);
  assign addr_ok = (frame.addr < AW'(NREGS));
  assign wr      = commit && op_ok && addr_ok;

  for (genvar i = 0; i < NREGS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              bank[i] <= DW'(reg_default(i));
      else if (wr && frame.addr == AW'(i))     bank[i] <= frame.data;
    end
  end

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(bank));  // R3

  AST_UNLISTED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && frame.addr >= AW'(NREGS)) |=> $stable(bank));  // R7

  AST_OPCODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !op_bypass && frame.op != OP_WRITE) |=> $stable(bank));  // R6
endmodule

// File: rtl/ser_ctl_bank.sv
module ser_ctl_bank
  import ser_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       sdi,
  input  logic       op_bypass,
  input  logic       stby_n,
  output logic       adc_clk_inv,
  output logic       dir_to_gain,
  output logic       dir_to_conv,
  output logic       low_rate,
  output logic       clamp_fast,
  output logic       dir_clamp_off,
  output logic [1:0] clamp_sel,
  output logic       strobe_inv,
  output logic       enable_inv,
  output logic [1:0] mon_sel,
  output logic [8:0] gain_code,
  output logic [6:0] black_target,
  output logic       ac_couple,
  output logic       standby,
  output logic       out_hiz,
  output logic       black_reset
);
  logic [2:0] pins_s;
  logic       cs_n_s, sck_s, sdi_s;
  logic [FRAME_BITS-1:0] frame_bits;
  logic       commit;
  logic [NUM_REGS-1:0][DATA_BITS-1:0] bank;
  word_t      m_a, m_b;
  logic       unused_bits;

  ser_ctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, sdi}), .q(pins_s));

  assign {cs_n_s, sck_s, sdi_s} = pins_s;

  ser_ctl_shift #(.NBITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_s(sck_s), .sdi_s(sdi_s),
    .frame(frame_bits), .commit(commit));

  ser_ctl_regs #(.NREGS(NUM_REGS), .DW(DATA_BITS), .AW(ADDR_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .frame(frame_t'(frame_bits)),
    .op_bypass(op_bypass), .bank(bank));

  assign m_a = bank[ADR_MODE_A];
  assign m_b = bank[ADR_MODE_B];

  assign adc_clk_inv   = m_a[6];
  assign dir_to_gain   = (m_a[5:4] == 2'b01);
  assign dir_to_conv   = m_a[5];
  assign low_rate      = m_a[3];
  assign clamp_fast    = m_b[7];
  assign dir_clamp_off = m_b[6];
  assign clamp_sel     = m_b[5:4];
  assign strobe_inv    = m_b[3];
  assign enable_inv    = m_b[2];
  assign mon_sel       = m_b[1:0];
  assign gain_code     = bank[ADR_GAIN][8:0];
  assign black_target  = bank[ADR_BLACK][6:0];
  assign ac_couple     = bank[ADR_TEST][6];

  assign standby     = m_a[0] | ~stby_n;
  assign out_hiz     = m_a[2] | standby;
  assign black_reset = m_a[1] | ~rst_n;

  assign unused_bits = ^{m_a[9:7], m_b[9:8], bank[ADR_GAIN][9],
                         bank[ADR_BLACK][9:7], bank[ADR_TEST][9:7], bank[ADR_TEST][5:0]};

  AST_STANDBY_FORCES_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> out_hiz);  // R11
endmodule

// File: tb/ser_ctl_bank_bench.sv
module ser_ctl_bank_bench;
  localparam int HALF   = 4;
  localparam int SETTLE = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rst_n, cs_n, sck, sdi, op_bypass, stby_n;
  logic adc_clk_inv, dir_to_gain, dir_to_conv, low_rate, clamp_fast, dir_clamp_off;
  logic [1:0] clamp_sel, mon_sel;
  logic strobe_inv, enable_inv, ac_couple, standby, out_hiz, black_reset;
  logic [8:0] gain_code;
  logic [6:0] black_target;

  ser_ctl_bank u_ser_ctl_bank (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .op_bypass(op_bypass), .stby_n(stby_n),
    .adc_clk_inv(adc_clk_inv), .dir_to_gain(dir_to_gain), .dir_to_conv(dir_to_conv),
    .low_rate(low_rate), .clamp_fast(clamp_fast), .dir_clamp_off(dir_clamp_off),
    .clamp_sel(clamp_sel), .strobe_inv(strobe_inv), .enable_inv(enable_inv),
    .mon_sel(mon_sel), .gain_code(gain_code), .black_target(black_target),
    .ac_couple(ac_couple), .standby(standby), .out_hiz(out_hiz), .black_reset(black_reset));

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int pend = 0;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [9:0] mdl [5];

  function automatic void model_reset();
    for (int i = 0; i < 5; i++) mdl[i] = (i == 3) ? 10'd64 : 10'd0;
  endfunction

  function automatic logic [31:0] expect_vec();
    logic [9:0] a, b;
    logic sb;
    a  = mdl[0];
    b  = mdl[1];
    sb = a[0] | ~stby_n;
    return {a[6], (a[5:4] == 2'b01), a[5], a[3], b[7], b[6], b[5:4], b[3], b[2], b[1:0],
            mdl[2][8:0], mdl[3][6:0], mdl[4][6], sb, a[2] | sb, a[1] | ~rst_n};
  endfunction

  function automatic logic [31:0] actual_vec();
    return {adc_clk_inv, dir_to_gain, dir_to_conv, low_rate, clamp_fast, dir_clamp_off,
            clamp_sel, strobe_inv, enable_inv, mon_sel, gain_code, black_target,
            ac_couple, standby, out_hiz, black_reset};
  endfunction

  // monitor: pops expected items and compares away from the active edge
  initial begin
    forever begin
      item_t it;
      wait (pend != 0);
      @(negedge clk);
      it = q.pop_front();
      compared++;
      if (actual_vec() !== it.exp) begin
        mismatched++;
        $display("FAIL %s actual=%h expected=%h", it.tag, actual_vec(), it.exp);
      end
      pend--;
    end
  end

  task automatic expect_now(input string tag);
    q.push_back('{expect_vec(), tag});
    pend++;
    wait (pend == 0);
    @(negedge clk);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input bit o0, input bit o1, input logic [3:0] addr,
                      input logic [9:0] data, input int rises, input bit mid_check);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < rises; i++) begin
      if (i == 0)       sdi = o0;
      else if (i == 1)  sdi = o1;
      else if (i < 6)   sdi = addr[i-2];
      else if (i < 16)  sdi = data[i-6];
      else              sdi = i[0];
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    if (mid_check) begin
      wait_clk(SETTLE);
      expect_now("R3 held until select rises");
    end
    cs_n = 1'b1;
    wait_clk(SETTLE);
    if (rises >= 16 && (op_bypass || (!o0 && o1)) && addr < 4'd5) mdl[addr] = data;
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; op_bypass = 1'b1; stby_n = 1'b1;
    model_reset();
    wait_clk(5);
    expect_now("R1 in reset");
    rst_n = 1'b1;
    wait_clk(3);
    expect_now("R1 defaults");

    send(1, 1, 4'd2, 10'h155, 16, 0); expect_now("R2 gain bit order");      // R2 R10
    send(0, 0, 4'd0, 10'h07F, 16, 0); expect_now("R8 word0 all fields");    // R8
    send(0, 0, 4'd0, 10'h05A, 16, 0); expect_now("R8 route to gain");       // R8
    send(0, 0, 4'd0, 10'h028, 16, 0); expect_now("R8 route to conv");       // R8
    send(0, 0, 4'd1, 10'h0E5, 16, 0); expect_now("R9 word1 decode");        // R9
    send(0, 0, 4'd1, 10'h11A, 16, 0); expect_now("R9 word1 alt");           // R9
    send(0, 0, 4'd3, 10'h07F, 16, 0); expect_now("R10 black max");          // R10
    send(0, 0, 4'd4, 10'h040, 16, 0); expect_now("R10 test ac couple");     // R10

    send(0, 0, 4'd2, 10'h0AA, 15, 0); expect_now("R4 short frame");         // R4
    send(0, 0, 4'd3, 10'h011, 20, 0); expect_now("R5 long frame");          // R5

    op_bypass = 1'b0;
    send(0, 0, 4'd2, 10'h033, 16, 0); expect_now("R6 op 00 blocked");       // R6
    send(1, 1, 4'd2, 10'h034, 16, 0); expect_now("R6 op 11 blocked");       // R6
    send(1, 0, 4'd2, 10'h035, 16, 0); expect_now("R6 op 10 blocked");       // R6
    send(0, 1, 4'd2, 10'h036, 16, 0); expect_now("R6 op 01 accepted");      // R6
    op_bypass = 1'b1;

    send(0, 0, 4'd7,  10'h3FF, 16, 0); expect_now("R7 addr 7 ignored");     // R7
    send(0, 0, 4'd15, 10'h3FF, 16, 0); expect_now("R7 addr 15 ignored");    // R7

    for (int k = 0; k < 6; k++) begin                                      // R12
      sdi = k[0]; wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
    end
    wait_clk(SETTLE);
    expect_now("R12 idle clocks ignored");
    send(0, 0, 4'd2, 10'h1C3, 16, 0); expect_now("R12 next frame clean");  // R12

    send(0, 0, 4'd2, 10'h0F0, 16, 1); expect_now("R3 after select rise");   // R3

    send(0, 0, 4'd0, 10'h000, 16, 0); expect_now("R11 all clear");          // R11
    stby_n = 1'b0; wait_clk(2); expect_now("R11 pin standby");              // R11
    stby_n = 1'b1;
    send(0, 0, 4'd0, 10'h004, 16, 0); expect_now("R11 output disable");     // R11
    send(0, 0, 4'd0, 10'h003, 16, 0); expect_now("R11 standby and black bit"); // R11

    rst_n = 1'b0; model_reset(); wait_clk(2);
    expect_now("R1 reset clears bank");                                     // R1 R11
    rst_n = 1'b1; wait_clk(3);
    expect_now("R1 after reset release");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule